// File: doc/BRIEF.md
# SPI FIFO and event unit

This block sits between a 32-bit register port and the byte-wide serial shift engine of an SPI controller. It holds a transmit FIFO and a receive FIFO of bytes, a mode register with two threshold fields, and an event/mask pair that drives one interrupt line. Software fills the transmit FIFO four bytes at a time with word writes. It drains the receive FIFO with word reads, which take four bytes, or byte reads, which take one. Byte reads let a tail of one to three bytes be collected without over-reading.

The shift engine pulls transmit bytes through a valid/ready pair and pushes received bytes through a second valid/ready pair. The event word shows live fill counts and empty/full flags for both FIFOs, and a sticky underflow flag that records a read of more bytes than the receive FIFO held. The interrupt is high whenever an event bit selected by the mask is set.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: After reset, the mode register reads 0x00000403, the event register reads 0x00000100, the mask reads 0, `irq_o` is low, `tx_valid_o` is low and `rx_ready_o` is high.
- R2: The mode register keeps only a transmit threshold in bits 13:8 and a receive threshold in bits 5:0. All other bits read zero, so writing 0xFFFFFFFF reads back 0x00003F3F.
- R3: A write to the transmit data register pushes four bytes, bits 31:24 first and bits 7:0 last. The shift engine receives them in that order through `tx_valid_o`/`tx_ready_i`. Once the 32-byte FIFO is full, further bytes are discarded.
- R4: A word read (`reg_rd_byte_i`=0) of the receive data register pops four bytes. The oldest byte is returned in bits 31:24.
- R5: A byte read (`reg_rd_byte_i`=1) of the receive data register pops one byte, returned in bits 7:0 with the upper bits zero.
- R6: In the event register, bits 29:24 hold the receive FIFO byte count and bits 21:16 hold the transmit FIFO byte count. Both follow the FIFO contents after every access.
- R7: Event bit 9 is set while the receive FIFO holds data, and bit 8 is set while the transmit FIFO has room. Writing the event register does not change the count fields or these two flags.
- R8: A receive read that asks for more bytes than are stored returns the stored bytes in their usual lanes with zeros in the missing lanes, and sets sticky event bit 12. Writing a one to bit 12 clears it, and so does writing 0xFFFFFFFF.
- R9: The mask register keeps bits 12, 9 and 8 and reads zero elsewhere. `irq_o` is high exactly when the event word ANDed with the mask is nonzero.
- R10: `rx_ready_o` is low while the receive FIFO holds 32 bytes. A byte pushed by the shift engine at that point is discarded, and the FIFO contents are unchanged.
- R11: The register offsets are mode 0x00, event 0x04, mask 0x08, transmit data 0x0C and receive data 0x10. The transmit data register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Register read strobe; pops the receive FIFO when the receive data offset is selected |
| reg_rd_byte_i | input | 1 | Selects a one-byte pop for a receive data read |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Masked event interrupt |
| tx_valid_o | output | 1 | Transmit FIFO has a byte for the shift engine |
| tx_byte_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Shift engine takes the transmit byte |
| rx_valid_i | input | 1 | Shift engine offers a received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive FIFO has room |

## Verification
The bench drives both FIFOs past their 32-byte limit. A design that wrapped its pointers or counted past the limit would replay stale bytes or report a count above 32. Word reads are made with only one to three bytes stored: a wrong lane order or a missing underflow flag shows up as swapped bytes or a clear bit 12. An event write of all ones is made while both FIFOs hold data, which catches a design that lets the write reach the live counts. Random sequences of pushes, pops, mask writes and clears are then compared against a byte-queue model after every step, including the level of `irq_o`.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
package spi_fe_pkg;
   localparam int unsigned ADDR_W      = 5;
   localparam int unsigned BUS_BYTES   = 4;

   localparam logic [ADDR_W-1:0] REG_MODE = 5'h00;
   localparam logic [ADDR_W-1:0] REG_EVT  = 5'h04;
   localparam logic [ADDR_W-1:0] REG_MASK = 5'h08;
   localparam logic [ADDR_W-1:0] REG_TXD  = 5'h0C;
   localparam logic [ADDR_W-1:0] REG_RXD  = 5'h10;

   localparam int unsigned EVT_TNF_BIT  = 8;
   localparam int unsigned EVT_RNE_BIT  = 9;
   localparam int unsigned EVT_UFL_BIT  = 12;
   localparam int unsigned TXCNT_LSB    = 16;
   localparam int unsigned RXCNT_LSB    = 24;
   localparam int unsigned CNT_FIELD_W  = 6;

   localparam int unsigned TXTHR_LSB    = 8;
   localparam int unsigned RXTHR_LSB    = 0;
   localparam int unsigned THR_W        = 6;
   localparam logic [THR_W-1:0] TXTHR_RST = 6'd4;
   localparam logic [THR_W-1:0] RXTHR_RST = 6'd3;

   localparam logic [31:0] FLAG_BITS =
      (32'h1 << EVT_UFL_BIT) | (32'h1 << EVT_RNE_BIT) | (32'h1 << EVT_TNF_BIT);
endpackage

// File: rtl/spi_fe_byte_fifo.sv
`timescale 1ns/1ps
module spi_fe_byte_fifo #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LANES = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned N_W   = $clog2(LANES + 1)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [N_W-1:0]       push_n_i,
   input  logic [LANES*8-1:0]   push_data_i,
   input  logic [N_W-1:0]       pop_n_i,
   output logic [LANES*8-1:0]   pop_data_o,
   output logic [CNT_W-1:0]     count_o,
   output logic                 short_o
);
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_fe_byte_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < LANES || LANES < 1) begin : g_bad_lanes
      $error("spi_fe_byte_fifo: need 1 <= LANES <= DEPTH");
   end

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] cnt_q, free_w, push_req, pop_req, push_acc, pop_acc;

   always_comb begin
      free_w   = CNT_W'(DEPTH) - cnt_q;
      push_req = CNT_W'(push_n_i);
      pop_req  = CNT_W'(pop_n_i);
      push_acc = (push_req > free_w) ? free_w : push_req;
      pop_acc  = (pop_req > cnt_q) ? cnt_q : pop_req;
      short_o  = pop_req > cnt_q;
   end

   always_ff @(posedge clk_i) begin
      for (int l = 0; l < int'(LANES); l++) begin
         if (CNT_W'(l) < push_acc) begin
            mem[wr_ptr_q + PTR_W'(l)] <= push_data_i[l*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         wr_ptr_q <= wr_ptr_q + PTR_W'(push_acc);
         rd_ptr_q <= rd_ptr_q + PTR_W'(pop_acc);
         cnt_q    <= cnt_q + push_acc - pop_acc;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign pop_data_o[l*8 +: 8] =
         (CNT_W'(l) < cnt_q) ? mem[rd_ptr_q + PTR_W'(l)] : 8'h00;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/spi_fe_evt.sv
`timescale 1ns/1ps
module spi_fe_evt
   import spi_fe_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CNT_W-1:0]  rx_cnt_i,
   input  logic [CNT_W-1:0]  tx_cnt_i,
   input  logic              tx_full_i,
   input  logic              uflow_set_i,
   input  logic              uflow_clr_i,
   input  logic              mask_wr_i,
   input  logic [31:0]       mask_wdata_i,
   output logic [31:0]       evt_o,
   output logic [31:0]       mask_o,
   output logic              irq_o
);
   if (CNT_W > CNT_FIELD_W) begin : g_bad_cnt
      $error("spi_fe_evt: FIFO count does not fit the event field");
   end

   logic        uflow_q;
   logic [31:0] mask_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         uflow_q <= 1'b0;
         mask_q  <= '0;
      end else begin
         if (uflow_set_i)      uflow_q <= 1'b1;
         else if (uflow_clr_i) uflow_q <= 1'b0;
         if (mask_wr_i)        mask_q  <= mask_wdata_i & FLAG_BITS;
      end
   end

   always_comb begin
      evt_o = '0;
      evt_o[RXCNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(rx_cnt_i);
      evt_o[TXCNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(tx_cnt_i);
      evt_o[EVT_UFL_BIT] = uflow_q;
      evt_o[EVT_RNE_BIT] = rx_cnt_i != '0;
      evt_o[EVT_TNF_BIT] = !tx_full_i;
   end

   assign mask_o = mask_q;
   assign irq_o  = |(evt_o & mask_q);
endmodule

// File: rtl/spi_fifo_evt_unit.sv
`timescale 1ns/1ps
module spi_fifo_evt_unit
   import spi_fe_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned N_W   = $clog2(BUS_BYTES + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [31:0]       reg_wdata_i,
   input  logic              reg_rd_i,
   input  logic              reg_rd_byte_i,
   output logic [31:0]       reg_rdata_o,
   output logic              irq_o,
   output logic              tx_valid_o,
   output logic [7:0]        tx_byte_o,
   input  logic              tx_ready_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_byte_i,
   output logic              rx_ready_o
);
   logic [CNT_W-1:0]        tx_cnt, rx_cnt;
   logic [BUS_BYTES*8-1:0]  tx_push_data, tx_pop_data, rx_push_data, rx_pop_data;
   logic [N_W-1:0]          tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
   logic                    tx_short, rx_short, rx_rd, tx_full;
   logic [31:0]             evt_word, mask_word, rx_word;
   logic [THR_W-1:0]        txthr_q, rxthr_q;

   // transmit FIFO: word writes push four bytes, MSB lane first
   for (genvar l = 0; l < BUS_BYTES; l++) begin : g_txpack
      assign tx_push_data[l*8 +: 8] = reg_wdata_i[(BUS_BYTES-1-l)*8 +: 8];
      assign rx_word[(BUS_BYTES-1-l)*8 +: 8] = rx_pop_data[l*8 +: 8];
   end

   assign tx_push_n  = (reg_wr_i && reg_addr_i == REG_TXD) ? N_W'(BUS_BYTES) : '0;
   assign tx_valid_o = tx_cnt != '0;
   assign tx_pop_n   = (tx_valid_o && tx_ready_i) ? N_W'(1) : '0;
   assign tx_byte_o  = tx_pop_data[7:0];
   assign tx_full    = tx_cnt == CNT_W'(DEPTH);

   spi_fe_byte_fifo #(.DEPTH(DEPTH), .LANES(BUS_BYTES)) u_tx_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_n_i   (tx_push_n),
      .push_data_i(tx_push_data),
      .pop_n_i    (tx_pop_n),
      .pop_data_o (tx_pop_data),
      .count_o    (tx_cnt),
      .short_o    (tx_short)
   );

   // receive FIFO: shift engine pushes single bytes, bus pops one or four
   assign rx_push_data = {{(BUS_BYTES-1)*8{1'b0}}, rx_byte_i};
   assign rx_push_n    = rx_valid_i ? N_W'(1) : '0;
   assign rx_ready_o   = rx_cnt != CNT_W'(DEPTH);
   assign rx_rd        = reg_rd_i && reg_addr_i == REG_RXD;
   assign rx_pop_n     = !rx_rd ? '0 : (reg_rd_byte_i ? N_W'(1) : N_W'(BUS_BYTES));

   spi_fe_byte_fifo #(.DEPTH(DEPTH), .LANES(BUS_BYTES)) u_rx_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_n_i   (rx_push_n),
      .push_data_i(rx_push_data),
      .pop_n_i    (rx_pop_n),
      .pop_data_o (rx_pop_data),
      .count_o    (rx_cnt),
      .short_o    (rx_short)
   );

   spi_fe_evt #(.CNT_W(CNT_W)) u_evt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rx_cnt_i    (rx_cnt),
      .tx_cnt_i    (tx_cnt),
      .tx_full_i   (tx_full),
      .uflow_set_i (rx_rd && rx_short),
      .uflow_clr_i (reg_wr_i && reg_addr_i == REG_EVT && reg_wdata_i[EVT_UFL_BIT]),
      .mask_wr_i   (reg_wr_i && reg_addr_i == REG_MASK),
      .mask_wdata_i(reg_wdata_i),
      .evt_o       (evt_word),
      .mask_o      (mask_word),
      .irq_o       (irq_o)
   );

   // mode register: threshold fields only
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         txthr_q <= TXTHR_RST;
         rxthr_q <= RXTHR_RST;
      end else if (reg_wr_i && reg_addr_i == REG_MODE) begin
         txthr_q <= reg_wdata_i[TXTHR_LSB +: THR_W];
         rxthr_q <= reg_wdata_i[RXTHR_LSB +: THR_W];
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         REG_MODE: begin
            reg_rdata_o[TXTHR_LSB +: THR_W] = txthr_q;
            reg_rdata_o[RXTHR_LSB +: THR_W] = rxthr_q;
         end
         REG_EVT:  reg_rdata_o = evt_word;
         REG_MASK: reg_rdata_o = mask_word;
         REG_RXD:  reg_rdata_o = reg_rd_byte_i ? {24'h0, rx_pop_data[7:0]} : rx_word;
         default:  reg_rdata_o = '0;
      endcase
   end

   logic unused_sig;
   assign unused_sig = ^{tx_short, tx_pop_data[BUS_BYTES*8-1:8]};
endmodule

// File: rtl/spi_fifo_evt_unit_chk.sv
`timescale 1ns/1ps
module spi_fifo_evt_unit_chk
   import spi_fe_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic              reg_wr_i,
   input logic [31:0]       reg_wdata_i,
   input logic              reg_rd_i,
   input logic [31:0]       reg_rdata_o,
   input logic              rx_valid_i,
   input logic [CNT_W-1:0]  tx_cnt,
   input logic [CNT_W-1:0]  rx_cnt,
   input logic [31:0]       evt_word
);
   logic rxd_rd, ufl_clr;
   assign rxd_rd  = reg_rd_i && reg_addr_i == REG_RXD;
   assign ufl_clr = reg_wr_i && reg_addr_i == REG_EVT && reg_wdata_i[EVT_UFL_BIT];

   // R10 / R3: neither FIFO ever holds more than DEPTH bytes
   a_r10_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_cnt <= CNT_W'(DEPTH)) && (tx_cnt <= CNT_W'(DEPTH)));

   // R3: a single access adds at most one word to the transmit FIFO
   a_r3_tx_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> int'(tx_cnt) <= int'($past(tx_cnt)) + 4);

   // R6: the receive count only falls when the bus reads the receive register
   a_r6_rx_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rxd_rd |=> rx_cnt >= $past(rx_cnt));

   // R10: a push into a full receive FIFO leaves it full, not wrapped
   a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_cnt == CNT_W'(DEPTH)) && rx_valid_i && !rxd_rd |=> rx_cnt == CNT_W'(DEPTH));

   // R8: underflow flag stays set until cleared
   a_r8_uflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_word[EVT_UFL_BIT] && !ufl_clr |=> evt_word[EVT_UFL_BIT]);

   // R8: a read of an empty receive FIFO returns zero
   a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rxd_rd && rx_cnt == '0 |-> reg_rdata_o == 32'h0);
endmodule

bind spi_fifo_evt_unit spi_fifo_evt_unit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_addr_i (reg_addr_i),
   .reg_wr_i   (reg_wr_i),
   .reg_wdata_i(reg_wdata_i),
   .reg_rd_i   (reg_rd_i),
   .reg_rdata_o(reg_rdata_o),
   .rx_valid_i (rx_valid_i),
   .tx_cnt     (tx_cnt),
   .rx_cnt     (rx_cnt),
   .evt_word   (evt_word)
);

// File: tb/spi_fifo_evt_unit_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_evt_unit_tb_top;
   localparam int DEPTH = 32;
   localparam logic [4:0] A_MODE = 5'h00, A_EVT = 5'h04, A_MASK = 5'h08,
                          A_TXD = 5'h0C, A_RXD = 5'h10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_rd_byte = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
   logic [7:0]  tx_byte, rx_byte = '0;

   int checks = 0, errors = 0;
   logic [7:0]  tx_q[$];
   logic [7:0]  rx_q[$];
   logic        m_uflow = 1'b0;
   logic [31:0] m_mask = '0;

   always #2.5 clk = ~clk;

   spi_fifo_evt_unit #(.DEPTH(DEPTH)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
      .reg_wdata_i(reg_wdata), .reg_rd_i(reg_rd), .reg_rd_byte_i(reg_rd_byte),
      .reg_rdata_o(reg_rdata), .irq_o(irq), .tx_valid_o(tx_valid),
      .tx_byte_o(tx_byte), .tx_ready_i(tx_ready), .rx_valid_i(rx_valid),
      .rx_byte_i(rx_byte), .rx_ready_o(rx_ready));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_evt();
      logic [31:0] e = '0;
      e[29:24] = 6'(rx_q.size());
      e[21:16] = 6'(tx_q.size());
      e[12]    = m_uflow;
      e[9]     = rx_q.size() != 0;
      e[8]     = tx_q.size() != DEPTH;
      return e;
   endfunction

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, input logic bm, output logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_rd_byte = bm; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0; reg_rd_byte = 1'b0;
   endtask

   task automatic op_txw(input logic [31:0] d);
      bus_wr(A_TXD, d);
      for (int i = 0; i < 4; i++) if (tx_q.size() < DEPTH) tx_q.push_back(d[31-8*i -: 8]);
   endtask

   task automatic op_txpop(input string tag, output logic [7:0] b);
      logic v;
      @(negedge clk); tx_ready = 1'b1;
      #1 v = tx_valid; b = tx_byte;
      @(negedge clk); tx_ready = 1'b0;
      if (tx_q.size() == 0) chk({tag, " tx_valid"}, {31'b0, v}, 32'd0);
      else begin
         chk({tag, " tx_valid"}, {31'b0, v}, 32'd1);
         chk({tag, " tx_byte"}, {24'b0, b}, {24'b0, tx_q.pop_front()});
      end
   endtask

   task automatic op_rxpush(input logic [7:0] b);
      chk("R10 rx_ready", {31'b0, rx_ready}, {31'b0, rx_q.size() < DEPTH});
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
      if (rx_q.size() < DEPTH) rx_q.push_back(b);
   endtask

   task automatic op_rxrd(input logic bm, input string tag, output logic [31:0] d);
      logic [31:0] e = '0;
      bus_rd(A_RXD, bm, d);
      if (bm) begin
         if (rx_q.size() == 0) m_uflow = 1'b1; else e[7:0] = rx_q.pop_front();
      end else begin
         if (rx_q.size() < 4) m_uflow = 1'b1;
         for (int i = 0; i < 4; i++) if (rx_q.size() != 0) e[31-8*i -: 8] = rx_q.pop_front();
      end
      chk(tag, d, e);
   endtask

   task automatic op_evtw(input logic [31:0] d);
      bus_wr(A_EVT, d);
      if (d[12]) m_uflow = 1'b0;
   endtask

   task automatic op_maskw(input logic [31:0] d);
      bus_wr(A_MASK, d);
      m_mask = d & 32'h0000_1300;
   endtask

   task automatic check_state(input string tag);
      logic [31:0] d, e;
      e = exp_evt();
      bus_rd(A_EVT, 1'b0, d);
      chk({tag, " event"}, d, e);
      chk("R9 irq", {31'b0, irq}, {31'b0, |(e & m_mask)});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic [7:0]  b;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R11 reset values
      bus_rd(A_MODE, 1'b0, d); chk("R1 mode reset", d, 32'h0000_0403);
      bus_rd(A_EVT, 1'b0, d);  chk("R1 event reset", d, 32'h0000_0100);
      bus_rd(A_MASK, 1'b0, d); chk("R1 mask reset", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'd0);
      chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
      chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);

      // R2 mode fields
      bus_wr(A_MODE, 32'hFFFF_FFFF);
      bus_rd(A_MODE, 1'b0, d); chk("R2 mode all ones", d, 32'h0000_3F3F);
      bus_wr(A_MODE, 32'h0000_0A05);
      bus_rd(A_MODE, 1'b0, d); chk("R2 mode value", d, 32'h0000_0A05);

      // R3 byte order and R11 TX reads zero
      op_txw(32'hA1B2_C3D4);
      bus_rd(A_TXD, 1'b0, d); chk("R11 txd reads zero", d, 32'h0);
      check_state("R6");
      op_txpop("R3", b); chk("R3 first byte", {24'b0, b}, 32'hA1);
      op_txpop("R3", b); chk("R3 second byte", {24'b0, b}, 32'hB2);
      op_txpop("R3", b); op_txpop("R3", b); chk("R3 last byte", {24'b0, b}, 32'hD4);
      op_txpop("R3 empty", b);

      // R3 overfill, then R7 event write on live state
      for (int i = 0; i < 9; i++) op_txw({8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
      check_state("R3 full");
      for (int i = 0; i < 5; i++) op_rxpush(8'(8'h60 + i));
      op_evtw(32'hFFFF_FFFF);
      check_state("R7 event write");
      for (int i = 0; i < DEPTH; i++) op_txpop("R3 drain", b);
      chk("R3 last kept byte", {24'b0, b}, 32'd31);

      // R4 / R5 word then byte reads
      op_rxrd(1'b0, "R4 word read", d); chk("R4 order", d, 32'h6061_6263);
      op_rxrd(1'b1, "R5 byte read", d); chk("R5 byte", d, 32'h64);
      check_state("R7 rx empty");

      // R8 underflow on empty and short reads, R9 irq
      op_maskw(32'hFFFF_FFFF);
      bus_rd(A_MASK, 1'b0, d); chk("R9 mask readback", d, 32'h0000_1300);
      op_rxrd(1'b1, "R8 empty byte read", d);
      check_state("R8 sticky");
      op_evtw(32'h0000_1000);
      check_state("R8 clear");
      op_rxpush(8'hC1); op_rxpush(8'hC2);
      op_rxrd(1'b0, "R8 short word", d); chk("R8 short lanes", d, 32'hC1C2_0000);
      check_state("R8 short");
      op_evtw(32'hFFFF_FFFF);
      op_maskw(32'h0000_0200);
      check_state("R9 rne masked");
      op_rxpush(8'h7E);
      check_state("R9 rne set");
      op_rxrd(1'b1, "R5 byte read", d);

      // R10 receive overfill
      for (int i = 0; i < DEPTH + 3; i++) op_rxpush(8'(i));
      check_state("R10 full");
      op_rxrd(1'b0, "R10 word after drop", d); chk("R10 first kept", d, 32'h0001_0203);
      while (rx_q.size() != 0) op_rxrd(1'b0, "R4 drain", d);

      // random mix
      for (int n = 0; n < 600; n++) begin
         case ($urandom_range(0, 9))
            0, 1:    op_txw($urandom);
            2, 3:    op_txpop("R3 random", b);
            4, 5, 6: op_rxpush(8'($urandom));
            7:       op_rxrd(1'($urandom), "R4 R5 random", d);
            8:       op_maskw($urandom);
            default: op_evtw($urandom);
         endcase
         check_state("R6 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule